// File: doc/BRIEF.md
# Holdover History Averaging Controller

This block sits between the loop filter of a digital PLL and its controlled oscillator. While at least one reference input is usable it passes the filter's frequency control word straight through. At a fixed decimated rate it also records that word into a circular history. From the history it keeps a running mean over a window that ends a programmable delay before the present. Because the window stops short of the present, disturbances in the last moments before a reference fault do not reach the stored value.

When every reference input is unavailable, and the initial calibration has finished, the block stops tracking. If the history window is full, it enters hold: the output starts at the last live control word and then steps toward the delayed average. Each step is a fixed fraction of the remaining gap. If the window is not yet full, it enters freeze and keeps the last live word. The block goes back to tracking only after the alarm condition has stayed clear for a set number of consecutive samples. The alarm detectors, the loop filter and the oscillator are outside this block; their signals arrive as plain inputs.

The FSM has three states. TRACK leaves on the *fault-with-history* transition to HOLD or the *fault-without-history* transition to FREEZE. HOLD and FREEZE each leave on the *recovered* transition back to TRACK.

Top module: `holdover_ctrl`

## Requirements
- R1: While reset is held, `mode` reads TRACK (encoding TRACK=0, HOLD=1, FREEZE=2), `hist_valid` is 0 and `out_word` is 0.
- R2: In TRACK, `out_word` equals the `ctl_word` present at the previous rising clock edge.
- R3: An input is unavailable when its `los` bit is set or (with USE_FOS=1) its `fos` bit is set. TRACK is left only when all N_IN inputs are unavailable at the same edge and `cal_done` is 1. Otherwise the block stays in TRACK.
- R4: With USE_FOS=0 the `fos` inputs have no effect, and only the `los` bits decide unavailability.
- R5: While the block stays in TRACK, one history sample of `ctl_word` is taken every DECIM clocks. The delay is D=2^min(`dly_code`,MAX_LOG2) samples and the window is A=2^min(`avg_code`,MAX_LOG2) samples. `hist_valid` rises once D+A samples have been taken since the last restart.
- R6: A change of either code restarts the history, and `hist_valid` is 0 from the next clock on.
- R7: Fault-with-history: if `hist_valid` is 1 at the fault edge, `mode` becomes HOLD and `out_word` still holds the last tracked word. The hold target is the mean of the samples aged D to D+A-1, where age 0 is the newest sample.
- R8: In HOLD, on each sample tick `out_word` moves toward the target by the difference arithmetically shifted right by RAMP_SHIFT, or by 1 if that shift gives 0. It never moves away from or past the target, so it settles exactly on it. Changes of `ctl_word` have no effect in HOLD.
- R9: Fault-without-history: if `hist_valid` is 0 at the fault edge, `mode` becomes FREEZE and `out_word` keeps the last tracked word, whatever `ctl_word` does.
- R10: Recovered: HOLD or FREEZE returns to TRACK on the RECOV_SAMPLES-th consecutive sample tick with the fault condition clear. Any clock with the fault present restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_done | input | 1 | Initial calibration finished |
| los | input | N_IN | Loss-of-signal alarm per input |
| fos | input | N_IN | Frequency-offset alarm per input |
| ctl_word | input | W | Live frequency control word from the loop filter |
| dly_code | input | 5 | History delay code |
| avg_code | input | 5 | Averaging length code |
| out_word | output | W | Control word for the oscillator |
| mode | output | 2 | 0 TRACK, 1 HOLD, 2 FREEZE |
| hist_valid | output | 1 | History window is full |

## Verification
Every output is registered. `out_word` in TRACK, the entry into HOLD or FREEZE, and the clearing of `hist_valid` after a code change all show one clock after the edge that samples the cause, so the bench drives on the falling edge and reads at the next falling edge. History samples, ramp steps and recovery counting happen only on sample ticks, one every DECIM clocks, and the bench never learns their phase. Those checks therefore use intervals of whole tick periods with a margin: a span of 8·k clocks holds exactly 2·k ticks, and a recovery check reads "still HOLD" after 8 clocks and "TRACK" after 12. Ramp checks follow the output every clock for monotonic approach and then test the settled value after enough ticks.

// File: rtl/holdover_pkg.sv
package holdover_pkg;

    typedef enum logic [1:0] {
        M_TRACK  = 2'd0,
        M_HOLD   = 2'd1,
        M_FREEZE = 2'd2
    } hold_mode_e;

endpackage

// File: rtl/holdover_tick.sv
module holdover_tick #(
    parameter int DECIM = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DECIM - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/holdover_history.sv
module holdover_history #(
    parameter int W        = 16,
    parameter int MAX_LOG2 = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] word,
    input  logic [4:0]   dly_code,
    input  logic [4:0]   avg_code,
    output logic [W-1:0] mean,
    output logic         valid
);
    localparam int AW    = MAX_LOG2 + 2;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = MAX_LOG2 + 3;
    localparam int SW    = W + MAX_LOG2 + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [CW-1:0] cnt_q, cnt_nx, dlen, alen, span;
    logic [SW-1:0] sum_q, add_v, sub_v;
    logic [4:0]    dly_q, avg_q, dl, al;
    logic          restart;

    always_comb begin
        dl      = (dly_code > 5'(MAX_LOG2)) ? 5'(MAX_LOG2) : dly_code;
        al      = (avg_code > 5'(MAX_LOG2)) ? 5'(MAX_LOG2) : avg_code;
        dlen    = CW'(1) << dl;
        alen    = CW'(1) << al;
        span    = dlen + alen;
        cnt_nx  = (cnt_q > span) ? cnt_q : cnt_q + 1'b1;
        restart = (dly_code != dly_q) || (avg_code != avg_q);
        add_v   = (cnt_nx > dlen) ? SW'(mem[wp_q - AW'(dlen)]) : '0;
        sub_v   = (cnt_nx > span) ? SW'(mem[wp_q - AW'(span)]) : '0;
        mean    = W'(sum_q >> al);
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            cnt_q <= '0;
            sum_q <= '0;
            valid <= 1'b0;
            dly_q <= '0;
            avg_q <= '0;
        end else begin
            dly_q <= dly_code;
            avg_q <= avg_code;
            if (restart) begin
                cnt_q <= '0;
                sum_q <= '0;
                valid <= 1'b0;
            end else if (push) begin
                wp_q  <= wp_q + 1'b1;
                cnt_q <= cnt_nx;
                sum_q <= sum_q + add_v - sub_v;
                valid <= (cnt_nx >= span);
            end
        end
    end
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl
    import holdover_pkg::*;
#(
    parameter int W             = 16,
    parameter int N_IN          = 2,
    parameter int USE_FOS       = 1,
    parameter int MAX_LOG2      = 3,
    parameter int DECIM         = 4,
    parameter int RAMP_SHIFT    = 2,
    parameter int RECOV_SAMPLES = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cal_done,
    input  logic [N_IN-1:0] los,
    input  logic [N_IN-1:0] fos,
    input  logic [W-1:0]    ctl_word,
    input  logic [4:0]      dly_code,
    input  logic [4:0]      avg_code,
    output logic [W-1:0]    out_word,
    output logic [1:0]      mode,
    output logic            hist_valid
);
    localparam int RCW = $clog2(RECOV_SAMPLES + 1);
    localparam int DW  = W + 1;

    hold_mode_e            state_q, state_nx;
    logic                  tick, push, all_fail;
    logic [N_IN-1:0]       unavail;
    logic [RCW-1:0]        rcnt_q;
    logic [W-1:0]          out_q, target_q, hist_mean;
    logic signed [DW-1:0]  diff, shd, step;

    generate
        if (USE_FOS != 0) begin : g_los_fos
            assign unavail = los | fos;
        end else begin : g_los_only
            assign unavail = los | (fos & {N_IN{1'b0}});
        end
    endgenerate

    assign all_fail = &unavail;

    holdover_tick #(.DECIM(DECIM)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign push = tick && (state_q == M_TRACK) && (state_nx == M_TRACK);

    holdover_history #(.W(W), .MAX_LOG2(MAX_LOG2)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .word     (ctl_word),
        .dly_code (dly_code),
        .avg_code (avg_code),
        .mean     (hist_mean),
        .valid    (hist_valid)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            M_TRACK: begin
                if (cal_done && all_fail)
                    state_nx = hist_valid ? M_HOLD : M_FREEZE;
            end
            M_HOLD, M_FREEZE: begin
                if (!all_fail && tick && rcnt_q == RCW'(RECOV_SAMPLES - 1))
                    state_nx = M_TRACK;
            end
            default: state_nx = M_TRACK;
        endcase
    end

    // State register and recovery counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M_TRACK;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == M_TRACK || all_fail) rcnt_q <= '0;
            else if (tick)                      rcnt_q <= rcnt_q + 1'b1;
        end
    end

    // Ramp step toward the hold target
    always_comb begin
        diff = $signed({1'b0, target_q}) - $signed({1'b0, out_q});
        shd  = diff >>> RAMP_SHIFT;
        if (diff == '0)     step = '0;
        else if (shd == '0) step = DW'(1);
        else                step = shd;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q    <= '0;
            target_q <= '0;
        end else begin
            unique case (state_q)
                M_TRACK: begin
                    out_q    <= ctl_word;
                    target_q <= hist_mean;
                end
                M_HOLD: begin
                    if (tick) out_q <= W'({1'b0, out_q} + $unsigned(step));
                end
                M_FREEZE: ;
                default: out_q <= out_q;
            endcase
        end
    end

    assign out_word = out_q;
    assign mode     = state_q;
endmodule

// File: rtl/holdover_ctrl_sva.sv
module holdover_ctrl_sva #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cal_done,
    input logic [W-1:0] ctl_word,
    input logic [4:0]   dly_code,
    input logic [4:0]   avg_code,
    input logic [W-1:0] out_word,
    input logic [1:0]   mode,
    input logic         hist_valid,
    input logic [W-1:0] target
);
    function automatic logic [W-1:0] gap(input logic [W-1:0] a, input logic [W-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    AST_TRACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> (out_word == $past(ctl_word))); // R2

    AST_NO_EXIT_BEFORE_CAL: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !cal_done) |=> (mode == 2'd0)); // R3

    AST_CODE_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
        (dly_code != $past(dly_code) || avg_code != $past(avg_code)) |=> !hist_valid); // R6

    AST_HOLD_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && $past(mode) == 2'd0) |-> $past(hist_valid)); // R7

    AST_RAMP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> (mode != 2'd1 || gap(out_word, target) <= $past(gap(out_word, target)))); // R8

    AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |=> $stable(out_word)); // R9

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd3)); // R1
endmodule

bind holdover_ctrl holdover_ctrl_sva #(.W(W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .cal_done   (cal_done),
    .ctl_word   (ctl_word),
    .dly_code   (dly_code),
    .avg_code   (avg_code),
    .out_word   (out_word),
    .mode       (mode),
    .hist_valid (hist_valid),
    .target     (target_q)
);

// File: tb/test_holdover_ctrl.sv
module test_holdover_ctrl;
    localparam int W = 16;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cal_done = 1'b0;
    logic [N-1:0] los = '0;
    logic [N-1:0] fos = '0;
    logic [W-1:0] ctl_word = '0;
    logic [4:0]   dly_code = 5'd1;
    logic [4:0]   avg_code = 5'd2;
    logic [W-1:0] out_word, out_word_b;
    logic [1:0]   mode, mode_b;
    logic         hist_valid, hist_valid_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    holdover_ctrl #(.W(W), .N_IN(N), .USE_FOS(1)) i_holdover_ctrl (
        .clk(clk), .rst(rst), .cal_done(cal_done), .los(los), .fos(fos),
        .ctl_word(ctl_word), .dly_code(dly_code), .avg_code(avg_code),
        .out_word(out_word), .mode(mode), .hist_valid(hist_valid)
    );

    holdover_ctrl #(.W(W), .N_IN(N), .USE_FOS(0)) i_holdover_ctrl_los (
        .clk(clk), .rst(rst), .cal_done(cal_done), .los(los), .fos(fos),
        .ctl_word(ctl_word), .dly_code(dly_code), .avg_code(avg_code),
        .out_word(out_word_b), .mode(mode_b), .hist_valid(hist_valid_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_n(3);
        chk(mode == 2'd0, "R1 mode", int'(mode), 0);
        chk(hist_valid == 1'b0, "R1 valid", int'(hist_valid), 0);
        chk(out_word == '0, "R1 out", int'(out_word), 0);
        rst = 1'b0;
        cal_done = 1'b1;
    endtask

    task automatic t_track();
        ctl_word = 16'd1234;
        wait_n(1);
        chk(out_word == 16'd1234, "R2 follow", int'(out_word), 1234);
        ctl_word = 16'd4321;
        wait_n(1);
        chk(out_word == 16'd4321, "R2 follow", int'(out_word), 4321);
    endtask

    task automatic t_cap();
        dly_code = 5'd0;
        avg_code = 5'd31;   // capped to 8, needs 9 samples
        wait_n(32);
        chk(hist_valid == 1'b0, "R5 not yet full", int'(hist_valid), 0);
        wait_n(12);
        chk(hist_valid == 1'b1, "R5 full after D+A", int'(hist_valid), 1);
    endtask

    task automatic t_code_change_freeze();
        dly_code = 5'd1;
        avg_code = 5'd2;
        wait_n(2);
        chk(hist_valid == 1'b0, "R6 cleared", int'(hist_valid), 0);
        ctl_word = 16'd700;
        wait_n(1);
        los = '1;
        wait_n(1);
        chk(mode == 2'd2, "R9 freeze", int'(mode), 2);
        chk(out_word == 16'd700, "R9 last word", int'(out_word), 700);
        ctl_word = 16'd9999;
        wait_n(20);
        chk(out_word == 16'd700 && mode == 2'd2, "R9 stable", int'(out_word), 700);
        los = '0;
        wait_n(12);
        chk(mode == 2'd0, "R10 freeze recover", int'(mode), 0);
    endtask

    task automatic t_hold();
        int bad = 0;
        ctl_word = 16'd2000;
        wait_n(60);
        chk(hist_valid == 1'b1, "R5 valid", int'(hist_valid), 1);
        ctl_word = 16'd3000;
        wait_n(8);
        ctl_word = 16'd5000;
        wait_n(8);
        los = '1;
        wait_n(1);
        chk(mode == 2'd1, "R7 hold", int'(mode), 1);
        chk(out_word == 16'd5000, "R7 starts at last word", int'(out_word), 5000);
        ctl_word = 16'd111;
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] prev = out_word;
            wait_n(1);
            if (out_word > prev || out_word < 16'd2500) bad++;
        end
        chk(bad == 0, "R8 monotonic approach", bad, 0);
        chk(out_word == 16'd2500, "R7 R8 settles on delayed mean", int'(out_word), 2500);
        los = '0;
        wait_n(4);
        chk(mode == 2'd1, "R10 too short", int'(mode), 1);
        los = '1;
        wait_n(1);
        los = '0;
        wait_n(8);
        chk(mode == 2'd1, "R10 count restarted", int'(mode), 1);
        wait_n(4);
        chk(mode == 2'd0, "R10 recovered", int'(mode), 0);
    endtask

    task automatic t_alarms();
        cal_done = 1'b0;
        los = '1;
        ctl_word = 16'd555;
        wait_n(10);
        chk(mode == 2'd0, "R3 calibration gate", int'(mode), 0);
        chk(out_word == 16'd555, "R3 still tracking", int'(out_word), 555);
        cal_done = 1'b1;
        los = 2'b01;
        wait_n(10);
        chk(mode == 2'd0, "R3 one input left", int'(mode), 0);
        fos = 2'b10;
        wait_n(2);
        chk(mode != 2'd0, "R3 los plus fos", int'(mode), 1);
        chk(mode_b == 2'd0, "R4 fos ignored", int'(mode_b), 0);
        los = '0;
        fos = '0;
        wait_n(16);
        chk(mode == 2'd0, "R10 back to track", int'(mode), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_track();
                t_cap();
                t_code_change_freeze();
                t_hold();
                t_alarms();
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule